// File: doc/BRIEF.md
# Single-PHY UTOPIA Transmit Cell Port

This block is the physical-layer side of a single-PHY UTOPIA transmit interface. An ATM-layer device writes cells into it one beat per clock over an 8-bit or 16-bit bus. Each beat is qualified by an active-low write enable. The first beat of a cell is flagged by a one-cycle start-of-cell strobe, and every beat carries an odd-parity bit. The port stores the beats in a four-cell buffer. It exposes a cell only after its last beat has arrived. Downstream logic drains the cells through a show-ahead read port that marks the first beat of each cell.

The write side paces itself on a cell-available flag, which has two meanings. In octet mode the flag drops while a few beats of space still remain, because the writer looks at it only every few writes. In cell mode the flag says whether a whole further cell will fit once the cell now in progress is finished. The port also catches three kinds of write error. A parity mismatch sets a sticky flag and counts, but the cell is kept. A start-of-cell that arrives too early throws away the short cell and counts it. A beat that finds the buffer full is dropped and sets a sticky overflow flag.

Top module: `utopia_tx_port`

## Requirements
- R1: After reset, rdValid is 0, txClav is 1, and parityErr, overflow, parityErrCount and runtCount are all 0.
- R2: A cell is CELL_BEATS beats long: 53 with an 8-bit bus, or 27 with a 16-bit bus (header, one pad byte, payload). It begins with a beat where txEnbN=0 and txSoc=1. A beat is taken only in a cycle where txEnbN=0.
- R3: Complete cells are read in the order they were written. rdData and rdSoc show the oldest stored beat while rdValid=1. rdSoc=1 only on the first beat of a cell. rdEn=1 removes the shown beat.
- R4: rdValid stays 0 until the last beat of a cell has been written. It becomes 1 on the clock edge that takes the last beat.
- R5: A beat has good parity when the XOR of all data bits and txPrty is 1. Any written beat with bad parity sets the sticky flag parityErr and adds one to parityErrCount. The beat is still stored.
- R6: A start-of-cell beat that arrives while a cell is incomplete discards that partial cell and adds one to runtCount. The beat then begins a new cell.
- R7: A beat written with txSoc=0 while no cell is open is ignored.
- R8: With modeCell=0 (octet mode), txClav is 1 exactly when the free space, counting beats of the partial cell as used, is more than 4 beats.
- R9: With modeCell=1 (cell mode), txClav is 1 exactly when the free space, less the beats still missing from the open cell, is at least CELL_BEATS.
- R10: A beat that finds the buffer full is dropped, together with any partial cell, and sets the sticky flag overflow. Cells already stored stay intact.
- R11: The buffer holds four complete cells at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txData | input | DATA_W | Cell data beat |
| txEnbN | input | 1 | Active-low write enable |
| txSoc | input | 1 | Start-of-cell strobe on the first beat |
| txPrty | input | 1 | Odd parity over txData |
| modeCell | input | 1 | 0: octet-level flag, 1: cell-level flag |
| txClav | output | 1 | Cell-available flag toward the writer |
| rdEn | input | 1 | Read strobe, removes the shown beat |
| rdData | output | DATA_W | Oldest stored beat of a complete cell |
| rdSoc | output | 1 | Shown beat is the first of its cell |
| rdValid | output | 1 | A complete cell beat is available |
| parityErr | output | 1 | Sticky parity error flag |
| parityErrCount | output | CNT_W | Beats with bad parity |
| runtCount | output | CNT_W | Cells discarded as runts |
| overflow | output | 1 | Sticky overflow flag |

## Verification
The assertions check on every cycle the rules that depend only on local history. Both error flags stay set once raised. A bad-parity beat always raises parityErr on the next edge. The runt counter only ever steps by one. A read cell can only appear after a write. Only the bench's scenarios can show the rest. These are the exact point where each handshake mode drops txClav, the runt and stray-beat cases seen through what the read port returns, a cell staying hidden until its last beat, and four full cells surviving an overflow attempt intact and in order.

// File: rtl/utopia_tx_pkg.sv
package utopia_tx_pkg;

  // Write-side strobes from the control to the cell store
  typedef struct packed {
    logic push;     // store the current beat
    logic discard;  // roll back the partial cell
    logic commit;   // make the partial cell readable
  } wrStrobe_t;

  // 8-bit bus: 53 beats; 16-bit bus: 27 words (one pad byte after header)
  function automatic int cellBeatsFor(int width);
    return (width == 16) ? 27 : 53;
  endfunction

endpackage

// File: rtl/utopia_tx_store.sv
module utopia_tx_store
  import utopia_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 212,
  parameter int CW     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrSoc,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdSoc,
  output logic              rdValid,
  output logic [CW-1:0]     commitCnt,
  output logic [CW-1:0]     pendCnt
);
  localparam int IW = $clog2(DEPTH);

  logic [DATA_W:0] mem [DEPTH];
  logic [IW-1:0]   wrIdx, commitIdx, rdIdx, baseIdx, nextWr;
  logic [CW-1:0]   nextPend;
  logic            pop;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] idx);
    return (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  always_comb begin
    pop      = rdEn && (commitCnt != '0);
    baseIdx  = strb.discard ? commitIdx : wrIdx;
    nextWr   = strb.push ? bump(baseIdx) : baseIdx;
    nextPend = (strb.discard ? '0 : pendCnt) + CW'(strb.push);
  end

  always_ff @(posedge clk) begin
    if (strb.push) mem[baseIdx] <= {wrSoc, wrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx     <= '0;
      commitIdx <= '0;
      rdIdx     <= '0;
      commitCnt <= '0;
      pendCnt   <= '0;
    end else begin
      wrIdx <= nextWr;
      if (pop) rdIdx <= bump(rdIdx);
      if (strb.commit) begin
        commitIdx <= nextWr;
        commitCnt <= commitCnt + nextPend - CW'(pop);
        pendCnt   <= '0;
      end else begin
        commitCnt <= commitCnt - CW'(pop);
        pendCnt   <= nextPend;
      end
    end
  end

  assign rdValid = (commitCnt != '0);
  assign rdData  = mem[rdIdx][DATA_W-1:0];
  assign rdSoc   = rdValid & mem[rdIdx][DATA_W];

endmodule

// File: rtl/utopia_tx_ctrl.sv
module utopia_tx_ctrl
  import utopia_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BEATS = 53,
  parameter int DEPTH      = 212,
  parameter int CW         = 8,
  parameter int CNT_W      = 16,
  parameter int OCT_MARGIN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txEnbN,
  input  logic              txSoc,
  input  logic              txPrty,
  input  logic              modeCell,
  input  logic [CW-1:0]     commitCnt,
  input  logic [CW-1:0]     pendCnt,
  output wrStrobe_t         strb,
  output logic              txClav,
  output logic              parityErr,
  output logic [CNT_W-1:0]  parityErrCount,
  output logic [CNT_W-1:0]  runtCount,
  output logic              overflow
);
  localparam int BW = $clog2(CELL_BEATS + 1);

  logic          inCell;
  logic [BW-1:0] beatCnt;
  logic          accept, startCell, contCell, full, overHit, badPar;
  logic [CW:0]   usedNow, spaceUsed, freeBeats, remain;

  always_comb begin
    accept    = !txEnbN;
    startCell = accept && txSoc;
    contCell  = accept && !txSoc && inCell;
    usedNow   = (CW+1)'(commitCnt) + (CW+1)'(pendCnt);
    spaceUsed = startCell ? (CW+1)'(commitCnt) : usedNow;
    full      = (spaceUsed == (CW+1)'(DEPTH));
    overHit   = (startCell || contCell) && full;
    badPar    = accept && !(^{txData, txPrty});
    strb.discard = startCell || overHit;
    strb.push    = (startCell || contCell) && !full;
    strb.commit  = contCell && !full && (beatCnt == BW'(CELL_BEATS - 1));
    freeBeats = (CW+1)'(DEPTH) - usedNow;
    remain    = inCell ? (CW+1)'(CELL_BEATS) - (CW+1)'(beatCnt) : '0;
    if (modeCell) txClav = (freeBeats >= remain + (CW+1)'(CELL_BEATS));
    else          txClav = (freeBeats > (CW+1)'(OCT_MARGIN));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCell         <= 1'b0;
      beatCnt        <= '0;
      parityErr      <= 1'b0;
      parityErrCount <= '0;
      runtCount      <= '0;
      overflow       <= 1'b0;
    end else begin
      if (badPar) begin
        parityErr      <= 1'b1;
        parityErrCount <= parityErrCount + 1'b1;
      end
      if (startCell && inCell) runtCount <= runtCount + 1'b1;
      if (overHit) begin
        overflow <= 1'b1;
        inCell   <= 1'b0;
        beatCnt  <= '0;
      end else if (startCell) begin
        inCell  <= 1'b1;
        beatCnt <= BW'(1);
      end else if (strb.commit) begin
        inCell  <= 1'b0;
        beatCnt <= '0;
      end else if (contCell) begin
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/utopia_tx_port.sv
module utopia_tx_port
  import utopia_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELLS      = 4,
  parameter int CNT_W      = 16,
  parameter int OCT_MARGIN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txEnbN,
  input  logic              txSoc,
  input  logic              txPrty,
  input  logic              modeCell,
  output logic              txClav,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdSoc,
  output logic              rdValid,
  output logic              parityErr,
  output logic [CNT_W-1:0]  parityErrCount,
  output logic [CNT_W-1:0]  runtCount,
  output logic              overflow
);
  localparam int CELL_BEATS = cellBeatsFor(DATA_W);
  localparam int DEPTH      = CELLS * CELL_BEATS;
  localparam int CW         = $clog2(DEPTH + 1);

  wrStrobe_t     strb;
  logic [CW-1:0] commitCnt, pendCnt;

  utopia_tx_ctrl #(
    .DATA_W(DATA_W), .CELL_BEATS(CELL_BEATS), .DEPTH(DEPTH),
    .CW(CW), .CNT_W(CNT_W), .OCT_MARGIN(OCT_MARGIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .txData(txData), .txEnbN(txEnbN),
    .txSoc(txSoc), .txPrty(txPrty), .modeCell(modeCell),
    .commitCnt(commitCnt), .pendCnt(pendCnt), .strb(strb),
    .txClav(txClav), .parityErr(parityErr),
    .parityErrCount(parityErrCount), .runtCount(runtCount),
    .overflow(overflow)
  );

  utopia_tx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(txData), .wrSoc(txSoc),
    .rdEn(rdEn), .rdData(rdData), .rdSoc(rdSoc), .rdValid(rdValid),
    .commitCnt(commitCnt), .pendCnt(pendCnt)
  );

endmodule

// File: rtl/utopia_tx_checker.sv
module utopia_tx_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] txData,
  input logic              txEnbN,
  input logic              txPrty,
  input logic              rdValid,
  input logic              parityErr,
  input logic [CNT_W-1:0]  runtCount,
  input logic              overflow
);
  AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> parityErr); // R5
  AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnbN && !(^{txData, txPrty})) |=> parityErr); // R5
  AST_RUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (runtCount != $past(runtCount)) |-> (runtCount == $past(runtCount) + 1'b1)); // R6
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R10
  AST_NO_CELL_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!rdValid && txEnbN) |=> !rdValid); // R4
endmodule

bind utopia_tx_port utopia_tx_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .txData(txData), .txEnbN(txEnbN), .txPrty(txPrty),
  .rdValid(rdValid), .parityErr(parityErr), .runtCount(runtCount),
  .overflow(overflow)
);

// File: tb/test_utopia_tx_port.sv
module test_utopia_tx_port;
  localparam int W    = 8;
  localparam int CELL = 53;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] txData = '0;
  logic         txEnbN = 1'b1, txSoc = 1'b0, txPrty = 1'b0, modeCell = 1'b0;
  logic         txClav, rdEn = 1'b0, rdSoc, rdValid, parityErr, overflow;
  logic [W-1:0] rdData;
  logic [15:0]  parityErrCount, runtCount;
  int checks = 0, errors = 0;

  utopia_tx_port i_utopia_tx_port (
    .clk(clk), .rstN(rstN), .txData(txData), .txEnbN(txEnbN), .txSoc(txSoc),
    .txPrty(txPrty), .modeCell(modeCell), .txClav(txClav), .rdEn(rdEn),
    .rdData(rdData), .rdSoc(rdSoc), .rdValid(rdValid), .parityErr(parityErr),
    .parityErrCount(parityErrCount), .runtCount(runtCount), .overflow(overflow)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] pat(int seed, int b);
    return W'(seed * 37 + b * 5 + 1);
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic beat(logic [W-1:0] d, logic soc, logic badPar);
    @(negedge clk);
    txData = d; txSoc = soc; txEnbN = 1'b0;
    txPrty = badPar ? (^d) : ~(^d);
  endtask

  task automatic idle();
    @(negedge clk);
    txEnbN = 1'b1; txSoc = 1'b0;
  endtask

  task automatic sendCell(int seed, int n, int badAt);
    for (int b = 0; b < n; b++) beat(pat(seed, b), b == 0, b == badAt);
  endtask

  task automatic readCell(string req, int seed);
    for (int b = 0; b < CELL; b++) begin
      @(negedge clk);
      check({req, " valid"}, rdValid, 1);
      check({req, " data"}, rdData, pat(seed, b));
      check({req, " soc"}, rdSoc, b == 0);
      rdEn = 1'b1;
    end
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic tResetState();
    check("R1 rdValid", rdValid, 0);
    check("R1 txClav", txClav, 1);
    check("R1 parityErr", parityErr, 0);
    check("R1 overflow", overflow, 0);
    check("R1 counts", parityErrCount + runtCount, 0);
  endtask

  task automatic tSingleCell();
    sendCell(1, CELL - 1, -1);
    idle();
    check("R4 partial hidden", rdValid, 0);
    beat(pat(1, CELL - 1), 1'b0, 1'b0);
    idle();
    check("R4 complete visible", rdValid, 1);
    readCell("R2 R3 single cell", 1);
    check("R3 drained", rdValid, 0);
  endtask

  task automatic tParity();
    sendCell(2, CELL, 7);
    idle();
    check("R5 flag", parityErr, 1);
    check("R5 count", parityErrCount, 1);
    readCell("R5 cell kept", 2);
    check("R5 sticky", parityErr, 1);
  endtask

  task automatic tRunt();
    sendCell(3, 10, -1);
    sendCell(4, CELL, -1);
    idle();
    check("R6 runt count", runtCount, 1);
    readCell("R6 new cell", 4);
    check("R6 runt not stored", rdValid, 0);
  endtask

  task automatic tStray();
    beat(8'hA5, 1'b0, 1'b0);
    beat(8'h5A, 1'b0, 1'b0);
    idle();
    check("R7 stray ignored", rdValid, 0);
    sendCell(5, CELL, -1);
    idle();
    readCell("R7 next cell clean", 5);
  endtask

  task automatic tFillAndFlags();
    modeCell = 1'b1;
    for (int c = 0; c < 3; c++) sendCell(10 + c, CELL, -1);
    idle();
    check("R9 room for one more", txClav, 1);
    beat(pat(13, 0), 1'b1, 1'b0);
    idle();
    check("R9 no room after current", txClav, 0);
    modeCell = 1'b0;
    #1 check("R8 octet plenty", txClav, 1);
    for (int b = 1; b < 48; b++) beat(pat(13, b), 1'b0, 1'b0);
    idle();
    check("R8 five free", txClav, 1);
    beat(pat(13, 48), 1'b0, 1'b0);
    idle();
    check("R8 four free", txClav, 0);
    for (int b = 49; b < CELL; b++) beat(pat(13, b), 1'b0, 1'b0);
    idle();
    check("R11 four cells held", overflow, 0);
    beat(8'h11, 1'b1, 1'b0);
    beat(8'h22, 1'b0, 1'b0);
    idle();
    check("R10 overflow flag", overflow, 1);
    for (int c = 0; c < 4; c++) readCell("R10 R11 stored cells intact", 10 + c);
    check("R10 nothing extra", rdValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tSingleCell();
    tParity();
    tRunt();
    tStray();
    tFillAndFlags();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule